// File: doc/BRIEF.md
# Programmable Phase-Shifted Square-Wave Reference

This block turns a fast system clock into two low-frequency square-wave references, about 1.95 kHz with the default parameters at a 2 MHz clock. The fixed reference comes from a chain of dividers. The second reference has the same frequency but lags the fixed one by a phase that software programs. Both are meant to drive a synchronous sampling system: one sets the excitation and the other places the sampling instants.

Every stage runs on the single system clock and uses clock-enable ticks. A prescaler makes a fine tick, nominally 1 MHz. A rate divider turns the fine ticks into a coarse tick, nominally 7.81 kHz. A two-bit synchronous counter on the coarse tick gives the double-frequency square wave and the fixed reference. A retriggerable one-shot counts fine ticks after each falling edge of the double-frequency wave. When it expires, a follower flip-flop copies the state of the fixed reference. The delay range covers half a reference period (0 to 180 degrees), and an inversion flag adds another half period. A new delay or inversion setting is taken over only at a rising edge of the fixed reference.

Top module: `phase_ref_gen`

## Requirements
- R1: While reset is high, and on the cycle after it, all three outputs are 0. After reset is released, `dbl_sq` first rises after exactly PRE_DIV*TICK_DIV (256) clocks.
- R2: `dbl_sq` is a 50% square wave that toggles every PRE_DIV*TICK_DIV (256) clocks.
- R3: `ref_fixed` toggles only in a cycle where `dbl_sq` falls, so its period is 4*PRE_DIV*TICK_DIV (1024) clocks.
- R4: With a delay of 0 and inversion off, `ref_shifted` equals `ref_fixed` in every cycle.
- R5: With a delay of D (1..255) and inversion off, `ref_shifted` equals `ref_fixed` as it was D*PRE_DIV clocks earlier. The phase lag is D/512 of a period.
- R6: A delay of 2*TICK_DIV (256) makes `ref_shifted` the complement of `ref_fixed`, a 180-degree lag.
- R7: `phase_inv` = 1 complements `ref_shifted` relative to the lagged value set by the delay.
- R8: `phase_dly` and `phase_inv` are captured only in the cycle where `ref_fixed` rises. Changes made between two such rises have no effect on `ref_shifted` until the next one.
- R9: A `phase_dly` value above 256 is treated as 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 2 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| phase_dly | input | DLY_W (9) | Delay in fine ticks, 0..256 |
| phase_inv | input | 1 | Add a further half-period shift |
| dbl_sq | output | 1 | Double-frequency square wave |
| ref_fixed | output | 1 | Fixed-phase reference |
| ref_shifted | output | 1 | Phase-programmable reference |

## Verification
Two events can fall in the same cycle. The one-shot can expire just as the next falling edge of `dbl_sq` reloads it, which happens when the delay is 256. A configuration capture also coincides with a reload, because every rising edge of `ref_fixed` is a falling edge of `dbl_sq`. The 256 and above-256 delay cases provoke the first collision. They are judged by requiring `ref_shifted` to be the exact complement of `ref_fixed`, since taking the follower value from the wrong side of the edge would give 0 degrees instead. The second collision is provoked by changing the settings just after a rising edge of `ref_fixed`. The test then confirms that the old phase holds for the rest of that period and that the new phase holds once it settles.

// File: rtl/phase_ref_pkg.sv
package phase_ref_pkg;
  // Source of a follower-flop update in a given cycle
  typedef enum logic [1:0] {
    SHOT_NONE    = 2'd0,
    SHOT_AT_EDGE = 2'd1,  // zero delay: fires with the triggering edge
    SHOT_EXPIRED = 2'd2   // countdown reached its last tick
  } shot_ev_e;
endpackage

// File: rtl/pr_tick_div.sv
module pr_tick_div #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else if (en)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pr_quad_counter.sv
module pr_quad_counter (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic q_dbl,
  output logic q_ref,
  output logic q_ref_nxt,
  output logic dbl_fall,
  output logic ref_rise
);
  logic [1:0] qs;
  logic [1:0] qs_inc;

  assign qs_inc    = qs + 2'd1;
  assign q_dbl     = qs[0];
  assign q_ref     = qs[1];
  assign q_ref_nxt = tick ? qs_inc[1] : qs[1];
  assign dbl_fall  = tick && qs[0];
  assign ref_rise  = tick && (qs == 2'b01);

  always_ff @(posedge clk) begin
    if (rst)       qs <= 2'b00;
    else if (tick) qs <= qs_inc;
  end
endmodule

// File: rtl/pr_oneshot.sv
module pr_oneshot
  import phase_ref_pkg::*;
#(
  parameter int unsigned DLY_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fine_tick,
  input  logic             trig,
  input  logic [DLY_W-1:0] dly,
  output shot_ev_e         ev
);
  logic [DLY_W-1:0] cnt;

  always_comb begin
    if (trig && (dly == '0))
      ev = SHOT_AT_EDGE;
    else if (fine_tick && (cnt == DLY_W'(1)))
      ev = SHOT_EXPIRED;
    else
      ev = SHOT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (trig)
      cnt <= dly;
    else if (fine_tick && (cnt != '0))
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/phase_ref_gen.sv
module phase_ref_gen
  import phase_ref_pkg::*;
#(
  parameter int unsigned PRE_DIV  = 2,
  parameter int unsigned TICK_DIV = 128,
  parameter int unsigned DLY_W    = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DLY_W-1:0] phase_dly,
  input  logic             phase_inv,
  output logic             dbl_sq,
  output logic             ref_fixed,
  output logic             ref_shifted
);
  // One period of dbl_sq in fine ticks = half a reference period
  localparam int unsigned DLY_MAX = 2 * TICK_DIV;

  logic             fine_tick, coarse_tick;
  logic             q_ref_nxt, dbl_fall, ref_rise;
  logic [DLY_W-1:0] dly_clamped, dly_q, dly_use;
  logic             inv_q, follow_q;
  shot_ev_e         shot_ev;

  pr_tick_div #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .en(1'b1), .tick(fine_tick)
  );

  pr_tick_div #(.DIV(TICK_DIV)) u_rate (
    .clk(clk), .rst(rst), .en(fine_tick), .tick(coarse_tick)
  );

  pr_quad_counter u_quad (
    .clk(clk), .rst(rst), .tick(coarse_tick),
    .q_dbl(dbl_sq), .q_ref(ref_fixed), .q_ref_nxt(q_ref_nxt),
    .dbl_fall(dbl_fall), .ref_rise(ref_rise)
  );

  assign dly_clamped = (phase_dly > DLY_W'(DLY_MAX)) ? DLY_W'(DLY_MAX) : phase_dly;
  // A capture coincides with a reload; the reload uses the new setting
  assign dly_use = ref_rise ? dly_clamped : dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
      inv_q <= 1'b0;
    end else if (ref_rise) begin
      dly_q <= dly_clamped;
      inv_q <= phase_inv;
    end
  end

  pr_oneshot #(.DLY_W(DLY_W)) u_shot (
    .clk(clk), .rst(rst), .fine_tick(fine_tick), .trig(dbl_fall),
    .dly(dly_use), .ev(shot_ev)
  );

  // Follower flop slaved to the fixed stage (J = ref, K = ~ref)
  always_ff @(posedge clk) begin
    if (rst) follow_q <= 1'b0;
    else begin
      case (shot_ev)
        SHOT_AT_EDGE: follow_q <= q_ref_nxt;
        SHOT_EXPIRED: follow_q <= ref_fixed;
        default:      follow_q <= follow_q;
      endcase
    end
  end

  assign ref_shifted = follow_q ^ inv_q;
endmodule

// File: rtl/phase_ref_checker.sv
module phase_ref_checker #(
  parameter int unsigned DLY_W = 9,
  parameter int unsigned HALF  = 256,
  parameter int unsigned DMAX  = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             dbl_sq,
  input logic             ref_fixed,
  input logic             ref_shifted,
  input logic [DLY_W-1:0] dly_q,
  input logic             inv_q
);
  localparam int unsigned SW = $clog2(HALF) + 2;
  logic [SW-1:0] since;
  logic          sq_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      since   <= '0;
      sq_prev <= 1'b0;
    end else begin
      sq_prev <= dbl_sq;
      since   <= (dbl_sq != sq_prev) ? SW'(1) : since + 1'b1;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!dbl_sq && !ref_fixed && !ref_shifted)); // R1

  AST_DBL_SPACING: assert property (@(posedge clk) disable iff (rst)
    (dbl_sq != sq_prev) |-> (since == SW'(HALF))); // R2

  AST_REF_ON_DBL_FALL: assert property (@(posedge clk) disable iff (rst)
    (ref_fixed != $past(ref_fixed)) |-> ($past(dbl_sq) && !dbl_sq)); // R3

  AST_CAPTURE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    ((dly_q != $past(dly_q)) || (inv_q != $past(inv_q))) |-> $rose(ref_fixed)); // R8

  AST_DLY_CLAMP: assert property (@(posedge clk) disable iff (rst)
    dly_q <= DLY_W'(DMAX)); // R9
endmodule

bind phase_ref_gen phase_ref_checker #(
  .DLY_W(DLY_W), .HALF(PRE_DIV * TICK_DIV), .DMAX(2 * TICK_DIV)
) u_chk (
  .clk(clk), .rst(rst), .dbl_sq(dbl_sq), .ref_fixed(ref_fixed),
  .ref_shifted(ref_shifted), .dly_q(dly_q), .inv_q(inv_q)
);

// File: tb/phase_ref_gen_bench.sv
`timescale 1ns/1ps
module phase_ref_gen_bench;
  localparam int CLK_PERIOD = 500;
  localparam int PRE = 2;
  localparam int TDIV = 128;
  localparam int HALF = PRE * TDIV;   // dbl_sq half period in clocks
  localparam int RPER = 4 * HALF;     // reference period in clocks
  localparam int HN = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] phase_dly = '0;
  logic       phase_inv = 1'b0;
  logic       dbl_sq, ref_fixed, ref_shifted;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic hist [0:HN-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_ref_gen u_phase_ref_gen (
    .clk(clk), .rst(rst), .phase_dly(phase_dly), .phase_inv(phase_inv),
    .dbl_sq(dbl_sq), .ref_fixed(ref_fixed), .ref_shifted(ref_shifted)
  );

  always @(negedge clk) begin
    hist[cyc % HN] = ref_fixed;
    cyc = cyc + 1;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    int n = 0;
    rst = 1'b1;
    repeat (4) step();
    chk(!dbl_sq && !ref_fixed && !ref_shifted, "R1 reset outputs",
        {dbl_sq, ref_fixed, ref_shifted}, 0);
    @(negedge clk); rst = 1'b0; #1;
    while (!dbl_sq && n < 2000) begin step(); n++; end
    chk(n == HALF, "R1 first dbl_sq rise", n, HALF);
  endtask

  task automatic test_dbl_period();
    int n;
    logic prv;
    for (int k = 0; k < 4; k++) begin
      prv = dbl_sq; n = 0;
      while (dbl_sq == prv && n < 2000) begin step(); n++; end
      chk(n == HALF, "R2 dbl_sq half period", n, HALF);
    end
  endtask

  task automatic test_ref_period();
    int n = 0, bad = 0;
    logic pr, pd;
    while (!(ref_fixed && !hist[(cyc - 2) % HN])) step();
    pr = ref_fixed; pd = dbl_sq;
    for (int k = 0; k < 2 * RPER; k++) begin
      step(); n++;
      if (ref_fixed != pr && !(pd && !dbl_sq)) bad++;
      if (ref_fixed && !pr && n != RPER) bad++;
      if (ref_fixed && !pr) n = 0;
      pr = ref_fixed; pd = dbl_sq;
    end
    chk(bad == 0, "R3 ref period and edge alignment", bad, 0);
  endtask

  // Compare ref_shifted against the lagged, optionally inverted ref_fixed
  task automatic check_phase(int d, bit inv, string req);
    int bad = 0;
    int lag;
    logic exp;
    lag = PRE * ((d > 256) ? 256 : d);
    for (int k = 0; k < RPER; k++) begin
      step();
      exp = hist[(cyc - 1 - lag) % HN] ^ inv;
      if (ref_shifted !== exp) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_phase(int d, bit inv, string req);
    @(negedge clk);
    phase_dly = 9'(d); phase_inv = inv;
    repeat (3 * RPER) step();
    check_phase(d, inv, req);
  endtask

  task automatic test_deferred();
    int bad = 0;
    run_phase(0, 1'b0, "R4 baseline before deferral");
    while (!(ref_fixed && !hist[(cyc - 2) % HN])) step();
    repeat (8) step();
    phase_dly = 9'd100; phase_inv = 1'b1;
    for (int k = 0; k < RPER - 40; k++) begin
      step();
      if (ref_shifted !== ref_fixed) bad++;
    end
    chk(bad == 0, "R8 settings held until ref rise", bad, 0);
    repeat (3 * RPER) step();
    check_phase(100, 1'b1, "R8 new settings after capture");
  endtask

  initial begin
    test_reset();
    test_dbl_period();
    test_ref_period();
    run_phase(0, 1'b0, "R4 zero delay");
    run_phase(1, 1'b0, "R5 delay 1");
    run_phase(77, 1'b0, "R5 delay 77");
    run_phase(255, 1'b0, "R5 delay 255");
    run_phase(256, 1'b0, "R6 delay 256");
    run_phase(0, 1'b1, "R7 inversion at zero delay");
    run_phase(140, 1'b1, "R7 inversion with delay 140");
    run_phase(400, 1'b0, "R9 delay 400 clamped");
    run_phase(511, 1'b1, "R9 delay 511 clamped with inversion");
    test_deferred();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule